// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block owns the single even-parity bit that accompanies a 32-bit multiplexed address/data bus and its 4-bit command/byte-enable lines. All logic runs in the bus clock domain. In any cycle where the local agent is driving the bus, the block computes even parity over the 36 bus bits. It presents that bit, with an output enable, in the next cycle. This matches the rule that parity trails its phase by one clock and is driven by whichever agent drove the lines.

When the agent is receiving, the caller marks each address or data phase with a strobe. The block registers the parity of the 36 bits seen in that phase. It then compares that value with the parity line sampled one clock later. A mismatch in a data phase pulses an active-low data error output two clocks after the data phase. A mismatch in an address phase pulses a separate active-low system error output in the same cycle. The caller handles arbitration, transaction sequencing, configuration decoding and pad tri-state control.

Top module: `pci_parity_unit`

## Requirements
- R1: The parity output is the XOR of all 32 address/data bits and all 4 command/byte-enable bits. The 37 bits together therefore hold an even number of ones.
- R2: The parity output enable is high in cycle N+1 exactly when the drive-enable input was high in cycle N, and reset was not applied at that edge.
- R3: While the parity output enable is low, the parity output is held at 0.
- R4: Suppose a receive data phase in cycle N (data strobe high, address strobe low, drive enable low) has parity that differs from the parity input sampled in cycle N+1. Then the data error output (active low) is 0 for exactly one clock, in cycle N+2.
- R5: Suppose a receive address phase in cycle N (address strobe high, drive enable low) has parity that differs from the parity input in cycle N+1. Then the system error output (active low) is 0 for exactly cycle N+2, and the data error output stays 1.
- R6: A receive phase whose parity matches the parity input of the following cycle raises no error.
- R7: Failing data phases in consecutive cycles produce data error pulses in consecutive cycles, and none is lost.
- R8: Phases in a cycle where drive enable is high are not checked, whatever the strobes and the later parity input are.
- R9: A cycle in which both strobes are low is not checked.
- R10: A synchronous active-low reset clears every pipeline stage. Both error outputs go to 1, and the parity output and its enable go to 0 from the first edge with reset low. An error in flight when reset arrives is dropped.
- R11: If both strobes are high in a receive cycle, the phase is treated as an address phase, so a mismatch is reported on the system error output only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data bus value in the current cycle |
| cbe_i | input | 4 | Command/byte-enable value in the current cycle |
| par_i | input | 1 | Parity line as seen on the bus |
| drive_en_i | input | 1 | The local agent drives ad/cbe this cycle |
| addr_vld_i | input | 1 | Current cycle is an address phase |
| data_vld_i | input | 1 | Current cycle is a data phase |
| par_o | output | 1 | Generated parity for the previous driven cycle |
| par_oe_o | output | 1 | Enable for driving par_o onto the bus |
| perr_n_o | output | 1 | Data parity error, active low, one-cycle pulse |
| serr_n_o | output | 1 | Address parity error, active low, one-cycle pulse |

## Verification
A corrupted phase-type stage would send an address error to the data error output, or the reverse. A stage that is not cleared would show a pulse with no failing phase behind it. Either fault is visible at the error pins two clocks after the phase that caused it. A wrong generator register shows up one clock after a driven cycle as a wrong parity value or enable. The model follows every output on every cycle, so each of these faults is reported in the first cycle it appears. Random traffic that mixes driven and received phases and good and bad parity is combined with directed back-to-back, dual-strobe and reset-in-flight cases.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

   // Kind of phase held in the check stage
   typedef enum logic [1:0] {
      PH_NONE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   // Address strobe wins when both are raised; driven cycles are never checked
   function automatic phase_e classify(input logic drv, input logic av, input logic dv);
      phase_e r;
      if (drv)     r = PH_NONE;
      else if (av) r = PH_ADDR;
      else if (dv) r = PH_DATA;
      else         r = PH_NONE;
      return r;
   endfunction

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
   parameter int W          = 36,
   parameter int TREE_STYLE = 1
) (
   input  logic [W-1:0] d,
   output logic         p
);
   localparam int LEVELS = $clog2(W);
   localparam int PW     = 1 << LEVELS;

   generate
      if (W < 1) begin : g_bad_w
         $error("pci_par_tree: W must be at least 1");
      end
      if (TREE_STYLE != 0 && TREE_STYLE != 1) begin : g_bad_style
         $error("pci_par_tree: TREE_STYLE must be 0 or 1");
      end

      if (TREE_STYLE == 0) begin : g_reduce
         assign p = ^d;
      end else begin : g_tree
         // Balanced XOR tree, zero-padded to a power of two
         for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
            logic [(PW >> l)-1:0] v;
            if (l == 0) begin : g_leaf
               assign v = PW'(d);
            end else begin : g_node
               for (genvar i = 0; i < (PW >> l); i++) begin : g_x
                  assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
               end
            end
         end
         assign p = g_lvl[LEVELS].v[0];
      end
   endgenerate

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_par,
   input  logic drive_en,
   output logic par_o,
   output logic par_oe_o
);
   logic par_q;
   logic oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         par_q <= drive_en ? bus_par : 1'b0;
         oe_q  <= drive_en;
      end
   end

   assign par_o    = par_q;
   assign par_oe_o = oe_q;

   p_par_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |=> (par_o == $past(bus_par)));

   p_oe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |=> par_oe_o);

   p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |=> !par_oe_o);

   p_par_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !par_oe_o |-> !par_o);

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
   import pci_par_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_par,
   input  logic par_i,
   input  logic drive_en,
   input  logic addr_vld,
   input  logic data_vld,
   output logic perr_n_o,
   output logic serr_n_o
);
   phase_e s_ph;
   logic   s_par;
   logic   perr_q;
   logic   serr_q;
   logic   mism;

   assign mism = s_par ^ par_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_ph   <= PH_NONE;
         s_par  <= 1'b0;
         perr_q <= 1'b0;
         serr_q <= 1'b0;
      end else begin
         s_ph   <= classify(drive_en, addr_vld, data_vld);
         s_par  <= bus_par;
         perr_q <= (s_ph == PH_DATA) && mism;
         serr_q <= (s_ph == PH_ADDR) && mism;
      end
   end

   assign perr_n_o = ~perr_q;
   assign serr_n_o = ~serr_q;

   p_perr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> $past(data_vld && !addr_vld && !drive_en, 2));

   p_serr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> $past(addr_vld && !drive_en, 2));

   p_one_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!perr_n_o && !serr_n_o));

   p_drive_unchecked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drive_en, 2) |-> (perr_n_o && serr_n_o));

   p_idle_unchecked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!addr_vld && !data_vld, 2) |-> (perr_n_o && serr_n_o));

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
   parameter int AD_W       = 32,
   parameter int CBE_W      = 4,
   parameter int TREE_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AD_W-1:0]  ad_i,
   input  logic [CBE_W-1:0] cbe_i,
   input  logic             par_i,
   input  logic             drive_en_i,
   input  logic             addr_vld_i,
   input  logic             data_vld_i,
   output logic             par_o,
   output logic             par_oe_o,
   output logic             perr_n_o,
   output logic             serr_n_o
);
   localparam int BUS_W = AD_W + CBE_W;

   generate
      if (AD_W < 1 || CBE_W < 1) begin : g_bad_width
         $error("pci_parity_unit: AD_W and CBE_W must be positive");
      end
   endgenerate

   logic bus_par;

   pci_par_tree #(.W(BUS_W), .TREE_STYLE(TREE_STYLE)) u_tree (
      .d ({cbe_i, ad_i}),
      .p (bus_par)
   );

   pci_par_gen u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_par  (bus_par),
      .drive_en (drive_en_i),
      .par_o    (par_o),
      .par_oe_o (par_oe_o)
   );

   pci_par_chk u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_par  (bus_par),
      .par_i    (par_i),
      .drive_en (drive_en_i),
      .addr_vld (addr_vld_i),
      .data_vld (data_vld_i),
      .perr_n_o (perr_n_o),
      .serr_n_o (serr_n_o)
   );

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |=> (perr_n_o && serr_n_o && !par_oe_o && !par_o));

   p_even_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en_i |=> ((^$past({cbe_i, ad_i})) == par_o));

endmodule

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

   typedef struct {
      logic        rst;
      logic        drv;
      logic        av;
      logic        dv;
      logic [31:0] ad;
      logic [3:0]  cbe;
      logic        par;
   } stim_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad_i = '0;
   logic [3:0]  cbe_i = '0;
   logic        par_i = 1'b0;
   logic        drive_en_i = 1'b0;
   logic        addr_vld_i = 1'b0;
   logic        data_vld_i = 1'b0;
   logic        par_o, par_oe_o, perr_n_o, serr_n_o;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   stim_t h1, h2;
   logic  lastp = 1'b0;

   always #5 clk = ~clk;

   pci_parity_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
      .drive_en_i(drive_en_i), .addr_vld_i(addr_vld_i), .data_vld_i(data_vld_i),
      .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o)
   );

   // Even parity by counting ones
   function automatic logic ref_par(input logic [31:0] a, input logic [3:0] c);
      int n = 0;
      for (int i = 0; i < 32; i++) n += int'(a[i]);
      for (int i = 0; i < 4; i++)  n += int'(c[i]);
      return logic'(n % 2);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Check outputs from the model history, then apply the next cycle's inputs
   task automatic step(input logic r, input logic drv, input logic av, input logic dv,
                       input logic [31:0] a, input logic [3:0] c, input logic p);
      logic  e_oe, e_par, mism, e_perr, e_serr;
      stim_t n;
      @(negedge clk);
      e_oe   = h1.rst && h1.drv;
      e_par  = e_oe ? ref_par(h1.ad, h1.cbe) : 1'b0;
      mism   = ref_par(h2.ad, h2.cbe) != h1.par;
      e_perr = h1.rst && h2.rst && !h2.drv && !h2.av && h2.dv && mism;
      e_serr = h1.rst && h2.rst && !h2.drv && h2.av && mism;
      chk("R2", par_oe_o, e_oe);
      chk(e_oe ? "R1" : "R3", par_o, e_par);
      chk("R4", perr_n_o, ~e_perr);
      chk("R5", serr_n_o, ~e_serr);
      n.rst = r; n.drv = drv; n.av = av; n.dv = dv; n.ad = a; n.cbe = c; n.par = p;
      h2 = h1;
      h1 = n;
      lastp = ref_par(a, c);
      rst_n = r; drive_en_i = drv; addr_vld_i = av; data_vld_i = dv;
      ad_i = a; cbe_i = c; par_i = p;
   endtask

   initial begin
      logic seed_dummy;
      h1 = '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0};
      h2 = h1;
      seed_dummy = logic'($urandom(32'h1d5e_0a07));
      // R10: reset state
      repeat (3) step(0, 1, 1, 1, 32'hFFFF_FFFF, 4'hF, 1);
      step(1, 0, 0, 0, 0, 0, 0);
      // R1, R2, R3: driven patterns
      step(1, 1, 1, 0, 32'hFFFF_FFFF, 4'hE, 0);
      step(1, 1, 0, 1, 32'hAAAA_5555, 4'h1, 0);
      step(1, 1, 0, 1, 32'h0000_0001, 4'h0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      // R4: bad data parity; R6: good data parity
      step(1, 0, 0, 1, 32'h1234_5678, 4'h3, 0);
      step(1, 0, 0, 0, 0, 0, ~lastp);
      step(1, 0, 0, 1, 32'h8765_4321, 4'hC, 0);
      step(1, 0, 0, 0, 0, 0, lastp);
      // R7: three consecutive failing data phases
      step(1, 0, 0, 1, 32'h0F0F_0F0F, 4'h7, 0);
      step(1, 0, 0, 1, 32'hDEAD_BEEF, 4'h2, ~lastp);
      step(1, 0, 0, 1, 32'h0000_0003, 4'h8, ~lastp);
      step(1, 0, 0, 0, 0, 0, ~lastp);
      step(1, 0, 0, 0, 0, 0, 0);
      // R5: bad address parity; R11: both strobes count as address
      step(1, 0, 1, 0, 32'hC000_0010, 4'h6, 0);
      step(1, 0, 1, 1, 32'h4000_0020, 4'h7, ~lastp);
      step(1, 0, 0, 0, 0, 0, ~lastp);
      // R8: driven phases with wrong parity later are ignored
      step(1, 1, 1, 1, 32'h5A5A_5A5A, 4'h9, 0);
      step(1, 0, 0, 0, 0, 0, ~lastp);
      // R9: no strobe, wrong parity ignored
      step(1, 0, 0, 0, 32'h0000_00FF, 4'h1, 0);
      step(1, 0, 0, 0, 0, 0, ~lastp);
      // R10: reset while a data error is in flight drops it
      step(1, 0, 0, 1, 32'h1111_1111, 4'h1, 0);
      step(0, 0, 0, 0, 0, 0, ~lastp);
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      // Random traffic
      for (int k = 0; k < 3000; k++) begin
         logic drv, av, dv, p, r;
         r   = ($urandom_range(0, 199) != 0);
         drv = ($urandom_range(0, 2) == 0);
         av  = ($urandom_range(0, 3) == 0);
         dv  = ($urandom_range(0, 1) == 0);
         p   = ($urandom_range(0, 9) < 3) ? ~lastp : lastp;
         step(r, drv, av, dv, $urandom, 4'($urandom), p);
      end
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule